// File: doc/BRIEF.md
# Time-of-Day Synchronisation Controller

This block holds the chip-level time-of-day (TOD) state machine of one chip in a multi-chip system. Firmware reaches it through a 64-bit register port. Each request carries a word offset, which is the byte address shifted right by three. Through this port firmware moves the state machine from its error state to not-set, then loads a value with either a running or a stopped start. A stopped load is released later with a start command. Firmware can also read a status word, a running flag, a role-control word and a sticky error word.

A broadcast port links the chip to its peers. Writing one of two trigger offsets sends a "send TOD" or an "invalidate TOD" transaction to the other chips. The sending chip's own state machine never sees its own broadcast. Transactions received from peers drive the local state machine. Two static strap inputs give the chip its role: primary, secondary, or neither.

All outputs are registered. Read data, the illegal-access pulse, the outgoing broadcast and the new state all appear in the cycle after the request that causes them.

Top module: `tod_sync_ctrl`

## Requirements
- R1: Reset puts the state in error (code 0), sets the error word to zero and sets the role-control word to bit 2 set, with bit 1 equal to the primary strap (bit numbering puts bit 0 at the most significant end of the 64-bit word). State codes are error=0, stopped=1, running=2 and not-set=7.
- R2: A write to offset 0x18 with bit 0 set moves the state to not-set from any state. With bit 0 clear the write is rejected and the state does not change.
- R3: A write to offset 0x21 is accepted only in not-set. It moves to stopped when bit 63 is set and to running when bit 63 is clear. In any other state it is rejected and the state does not change.
- R4: A write to offset 0x22 is accepted only in stopped, and moves the state to running. In any other state it is rejected and the state does not change.
- R5: A received invalidate (rx_kind=1) forces not-set from any state. A received send (rx_kind=0) moves not-set to running. In any other state a received send is rejected and ignored.
- R6: A write to offset 0x15 emits a one-cycle broadcast of kind 0 (send), and a write to offset 0x16 emits one of kind 1 (invalidate). Neither changes the local state.
- R7: A read of offset 0x08 returns bits 6–10, 12, 21 and 26 always set, and bit 20 set only while running. It also returns exactly one role bit: bit 23 for primary (primary wins when both straps are high), bit 24 for secondary only, and bit 25 for neither.
- R8: A read of offset 0x24 returns bit 4 set while running and zero in every other state.
- R9: Any set bit of hw_err forces the error state and sets the same bit, counted from the least significant end, of the error word at offset 0x30. A write to 0x30 clears the bits written as 1. A new event wins over a clear in the same cycle.
- R10: A write to offset 0x07 keeps only bits 0–31. Bit 1 is forced to the primary strap and bit 2 is forced to 1. Bits 32–63 read as zero.
- R11: A rejected command, a rejected received send, a read or write of an offset with no meaning for that direction, and a write to a read-only offset each raise illegal_pulse for exactly one cycle. Such reads return zero.
- R12: A read returns its data with rd_valid high in the cycle after the request. Writes do not raise rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_primary | input | 1 | Static strap: chip is primary master |
| strap_secondary | input | 1 | Static strap: chip is backup master |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ofs | input | OFS_W | Word offset (byte address >> 3) |
| req_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| illegal_pulse | output | 1 | One-cycle rejected-access flag |
| tx_valid | output | 1 | Outgoing broadcast strobe |
| tx_kind | output | 1 | Outgoing kind: 0 send, 1 invalidate |
| rx_valid | input | 1 | Incoming peer broadcast strobe |
| rx_kind | input | 1 | Incoming kind: 0 send, 1 invalidate |
| hw_err | input | ERR_W | Hardware error event bits |
| tod_state | output | 3 | Current state code |

## Verification
The stopped state is the hardest to reach. It is only entered from not-set through a load with bit 63 set, and not-set itself first needs a good load-mod write or a received invalidate. The bench therefore builds each scenario as an explicit command chain from reset. Error, not-set, stopped and running are reached in sequence, and every reject case (start outside stopped, load outside not-set, received send while running) is applied in the state where it must be refused. The role bits depend on straps that are static, so the bench changes the straps only while reset is held, then reads the status word again.

// File: rtl/tod_sync_pkg.sv
// Package: shared types, state codes and register offsets of the TOD
// synchronisation controller. Assumes 64-bit register words with bit 0
// at the most significant end.
package tod_sync_pkg;

    localparam int WORD_W = 64;

    typedef enum logic [2:0] {
        TS_ERROR   = 3'd0,
        TS_STOPPED = 3'd1,
        TS_RUNNING = 3'd2,
        TS_NOT_SET = 3'd7
    } tod_state_e;

    localparam logic BC_SEND  = 1'b0;
    localparam logic BC_INVAL = 1'b1;

    localparam logic [7:0] OFS_ROLE_CTRL = 8'h07;
    localparam logic [7:0] OFS_STATUS    = 8'h08;
    localparam logic [7:0] OFS_TX_SEND   = 8'h15;
    localparam logic [7:0] OFS_TX_INVAL  = 8'h16;
    localparam logic [7:0] OFS_ARM       = 8'h18;
    localparam logic [7:0] OFS_LOAD      = 8'h21;
    localparam logic [7:0] OFS_START     = 8'h22;
    localparam logic [7:0] OFS_RUNFLAG   = 8'h24;
    localparam logic [7:0] OFS_ERRWORD   = 8'h30;

    // Decoded register command set, one strobe per action.
    typedef struct packed {
        logic arm_good;
        logic arm_bad;
        logic load;
        logic load_stop;
        logic start;
        logic tx_send;
        logic tx_inval;
        logic ctrl_wr;
        logic err_clr;
        logic rd_ctrl;
        logic rd_status;
        logic rd_runflag;
        logic rd_err;
        logic unknown;
    } tod_cmd_t;

    // Convert MSB-first bit number to a vector index.
    function automatic int mb(input int n);
        return WORD_W - 1 - n;
    endfunction

endpackage

// File: rtl/tod_sync_decode.sv
// Module: request decoder. Turns one register request into command
// strobes. Assumes a request lasts one cycle; purely combinational.
module tod_sync_decode
    import tod_sync_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [OFS_W-1:0]      req_ofs,
    input  logic [WORD_W-1:0]     req_wdata,
    output tod_cmd_t              cmd
);

    localparam int PAD_W = (OFS_W > 8) ? OFS_W - 8 : 0;

    logic wr;
    logic rd;
    logic [OFS_W-1:0] o;

    assign wr = req_valid && req_write;
    assign rd = req_valid && !req_write;
    assign o  = req_ofs;

    // Decode each offset and flag anything with no meaning for the direction.
    always_comb begin
        cmd = '0;
        if (wr) begin
            case (o)
                OFS_W'(OFS_ARM): begin
                    cmd.arm_good = req_wdata[mb(0)];
                    cmd.arm_bad  = !req_wdata[mb(0)];
                end
                OFS_W'(OFS_LOAD): begin
                    cmd.load      = 1'b1;
                    cmd.load_stop = req_wdata[mb(63)];
                end
                OFS_W'(OFS_START):     cmd.start    = 1'b1;
                OFS_W'(OFS_TX_SEND):   cmd.tx_send  = 1'b1;
                OFS_W'(OFS_TX_INVAL):  cmd.tx_inval = 1'b1;
                OFS_W'(OFS_ROLE_CTRL): cmd.ctrl_wr  = 1'b1;
                OFS_W'(OFS_ERRWORD):   cmd.err_clr  = 1'b1;
                default:               cmd.unknown  = 1'b1;
            endcase
        end else if (rd) begin
            case (o)
                OFS_W'(OFS_ROLE_CTRL): cmd.rd_ctrl    = 1'b1;
                OFS_W'(OFS_STATUS):    cmd.rd_status  = 1'b1;
                OFS_W'(OFS_RUNFLAG):   cmd.rd_runflag = 1'b1;
                OFS_W'(OFS_ERRWORD):   cmd.rd_err     = 1'b1;
                default:               cmd.unknown    = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/tod_sync_fsm.sv
// Module: TOD state machine. Applies hardware errors, peer broadcasts and
// register commands in priority order: hardware error, received
// invalidate, arm, load, start, received send. Rejections are computed
// against the current state and reported combinationally.
module tod_sync_fsm
    import tod_sync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       err_any,
    input  logic       rx_valid,
    input  logic       rx_kind,
    input  logic       arm_good,
    input  logic       load,
    input  logic       load_stop,
    input  logic       start,
    output tod_state_e state,
    output logic       reject
);

    tod_state_e state_d;
    logic rx_send;
    logic rx_inval;
    logic load_rej;
    logic start_rej;
    logic rx_send_rej;

    assign rx_send  = rx_valid && (rx_kind == BC_SEND);
    assign rx_inval = rx_valid && (rx_kind == BC_INVAL);

    // Commands that do not fit the current state.
    always_comb begin
        load_rej    = load    && (state != TS_NOT_SET);
        start_rej   = start   && (state != TS_STOPPED);
        rx_send_rej = rx_send && (state != TS_NOT_SET);
        reject      = load_rej || start_rej || rx_send_rej;
    end

    // Next-state selection by priority.
    always_comb begin
        state_d = state;
        if (err_any) begin
            state_d = TS_ERROR;
        end else if (rx_inval || arm_good) begin
            state_d = TS_NOT_SET;
        end else if (load) begin
            if (state == TS_NOT_SET) begin
                state_d = load_stop ? TS_STOPPED : TS_RUNNING;
            end
        end else if (start) begin
            if (state == TS_STOPPED) begin
                state_d = TS_RUNNING;
            end
        end else if (rx_send) begin
            if (state == TS_NOT_SET) begin
                state_d = TS_RUNNING;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TS_ERROR;
        else        state <= state_d;
    end

    p_enc_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state inside {TS_ERROR, TS_STOPPED, TS_RUNNING, TS_NOT_SET});

    p_err_forces_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |=> state == TS_ERROR);

    p_inval_forces_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_inval && !err_any) |=> state == TS_NOT_SET);

    p_run_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_RUNNING && $past(state) != TS_RUNNING)
            |-> ($past(state) == TS_NOT_SET || $past(state) == TS_STOPPED));

    p_start_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state != TS_STOPPED && !err_any && !rx_valid && !arm_good && !load)
            |=> $stable(state));

endmodule

// File: rtl/tod_sync_regs.sv
// Module: role-control word and sticky error word. Assumes the primary
// strap is static; control keeps its top 32 bits with bit 1 tied to the
// strap and bit 2 tied high.
module tod_sync_regs
    import tod_sync_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_primary,
    input  logic              ctrl_wr,
    input  logic              err_clr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ERR_W-1:0]  hw_err,
    output logic [WORD_W-1:0] ctrl_word,
    output logic [WORD_W-1:0] err_word
);

    localparam int KEEP_W = WORD_W / 2;
    localparam int B1 = KEEP_W - 2;
    localparam int B2 = KEEP_W - 3;

    logic [KEEP_W-1:0] ctrl_q;
    logic [ERR_W-1:0]  err_q;
    logic [KEEP_W-1:0] ctrl_d;

    // Apply forced bits to incoming control data.
    always_comb begin
        ctrl_d     = wdata[WORD_W-1 -: KEEP_W];
        ctrl_d[B1] = strap_primary;
        ctrl_d[B2] = 1'b1;
    end

    // Role-control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            ctrl_q[B1] <= strap_primary;
            ctrl_q[B2] <= 1'b1;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_d;
        end
    end

    // Sticky error register with write-one-to-clear; new events win.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= '0;
        else if (err_clr) err_q <= (err_q & ~wdata[ERR_W-1:0]) | hw_err;
        else              err_q <= err_q | hw_err;
    end

    assign ctrl_word = {ctrl_q, {(WORD_W-KEEP_W){1'b0}}};
    assign err_word  = {{(WORD_W-ERR_W){1'b0}}, err_q};

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_err) |=> ((err_q & $past(hw_err)) == $past(hw_err)));

    p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ctrl_q));

endmodule

// File: rtl/tod_sync_ctrl.sv
// Module: top of the TOD synchronisation controller. Decodes register
// requests, runs the state machine, keeps the control and error words,
// registers read data, the illegal-access pulse and outgoing broadcasts.
// Assumes static straps and single-cycle request and receive strobes.
module tod_sync_ctrl
    import tod_sync_pkg::*;
#(
    parameter int OFS_W = 8,
    parameter int ERR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_primary,
    input  logic              strap_secondary,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [OFS_W-1:0]  req_ofs,
    input  logic [63:0]       req_wdata,
    output logic              rd_valid,
    output logic [63:0]       rd_data,
    output logic              illegal_pulse,
    output logic              tx_valid,
    output logic              tx_kind,
    input  logic              rx_valid,
    input  logic              rx_kind,
    input  logic [ERR_W-1:0]  hw_err,
    output logic [2:0]        tod_state
);

    tod_cmd_t          cmd;
    tod_state_e        state;
    logic              fsm_reject;
    logic [WORD_W-1:0] ctrl_word;
    logic [WORD_W-1:0] err_word;
    logic [WORD_W-1:0] status_word;
    logic [WORD_W-1:0] runflag_word;
    logic [WORD_W-1:0] rd_mux;
    logic              illegal_d;

    tod_sync_decode #(.OFS_W(OFS_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ofs   (req_ofs),
        .req_wdata (req_wdata),
        .cmd       (cmd)
    );

    tod_sync_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_any   (|hw_err),
        .rx_valid  (rx_valid),
        .rx_kind   (rx_kind),
        .arm_good  (cmd.arm_good),
        .load      (cmd.load),
        .load_stop (cmd.load_stop),
        .start     (cmd.start),
        .state     (state),
        .reject    (fsm_reject)
    );

    tod_sync_regs #(.ERR_W(ERR_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_primary (strap_primary),
        .ctrl_wr       (cmd.ctrl_wr),
        .err_clr       (cmd.err_clr),
        .wdata         (req_wdata),
        .hw_err        (hw_err),
        .ctrl_word     (ctrl_word),
        .err_word      (err_word)
    );

    // Build the status word from fixed bits, run flag and role straps.
    always_comb begin
        status_word = '0;
        for (int b = 6; b <= 10; b++) status_word[mb(b)] = 1'b1;
        status_word[mb(12)] = 1'b1;
        status_word[mb(21)] = 1'b1;
        status_word[mb(26)] = 1'b1;
        status_word[mb(20)] = (state == TS_RUNNING);
        if (strap_primary)        status_word[mb(23)] = 1'b1;
        else if (strap_secondary) status_word[mb(24)] = 1'b1;
        else                      status_word[mb(25)] = 1'b1;
    end

    // Build the run-flag word.
    always_comb begin
        runflag_word = '0;
        runflag_word[mb(4)] = (state == TS_RUNNING);
    end

    // Select read data; unknown offsets give zero.
    always_comb begin
        rd_mux = '0;
        if (cmd.rd_ctrl)    rd_mux = ctrl_word;
        if (cmd.rd_status)  rd_mux = status_word;
        if (cmd.rd_runflag) rd_mux = runflag_word;
        if (cmd.rd_err)     rd_mux = err_word;
    end

    assign illegal_d = fsm_reject || cmd.arm_bad || cmd.unknown;

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid      <= 1'b0;
            rd_data       <= '0;
            illegal_pulse <= 1'b0;
            tx_valid      <= 1'b0;
            tx_kind       <= BC_SEND;
        end else begin
            rd_valid      <= req_valid && !req_write;
            rd_data       <= (req_valid && !req_write) ? rd_mux : '0;
            illegal_pulse <= illegal_d;
            tx_valid      <= cmd.tx_send || cmd.tx_inval;
            tx_kind       <= cmd.tx_inval ? BC_INVAL : BC_SEND;
        end
    end

    assign tod_state = state;

    p_illegal_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_pulse |-> $past(req_valid || rx_valid));

    p_tx_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(req_valid && req_write));

    p_rd_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));

    p_tx_local_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.tx_inval && !rx_valid && hw_err == '0) |=> $stable(state));

endmodule

// File: tb/sim_tod_sync_ctrl.sv
`timescale 1ns/1ps
module sim_tod_sync_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_primary = 1'b1;
    logic        strap_secondary = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_ofs = '0;
    logic [63:0] req_wdata = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        illegal_pulse;
    logic        tx_valid;
    logic        tx_kind;
    logic        rx_valid = 1'b0;
    logic        rx_kind = 1'b0;
    logic [7:0]  hw_err = '0;
    logic [2:0]  tod_state;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tod_sync_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .strap_primary(strap_primary), .strap_secondary(strap_secondary),
        .req_valid(req_valid), .req_write(req_write), .req_ofs(req_ofs),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .illegal_pulse(illegal_pulse), .tx_valid(tx_valid), .tx_kind(tx_kind),
        .rx_valid(rx_valid), .rx_kind(rx_kind), .hw_err(hw_err),
        .tod_state(tod_state)
    );

    function automatic logic [63:0] bm(input int n);
        return 64'h1 << (63 - n);
    endfunction

    function automatic logic [63:0] status_exp(input bit run, input bit pri, input bit sec);
        logic [63:0] v;
        v = bm(6) | bm(7) | bm(8) | bm(9) | bm(10) | bm(12) | bm(21) | bm(26);
        if (run) v |= bm(20);
        if (pri) v |= bm(23);
        else if (sec) v |= bm(24);
        else v |= bm(25);
        return v;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit pri, input bit sec);
        @(negedge clk);
        rst_n = 1'b0;
        strap_primary = pri;
        strap_secondary = sec;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One write; outputs sampled at the following falling edge.
    task automatic wr(input logic [7:0] ofs, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_ofs = ofs; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] ofs, output logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_ofs = ofs;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data;
    endtask

    task automatic rx(input logic k);
        @(negedge clk);
        rx_valid = 1'b1; rx_kind = k;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [63:0] d;
        do_reset(1, 0);
        chk("R1 reset state", 64'(tod_state), 64'd0);
        rd(8'h07, d);
        chk("R1 ctrl reset", d, bm(1) | bm(2));
        chk("R12 rd_valid", 64'(rd_valid), 64'd1);
        rd(8'h30, d);
        chk("R1 err reset", d, 64'd0);
        rd(8'h08, d);
        chk("R7 status primary err", d, status_exp(0, 1, 0));
    endtask

    task automatic t_arm_load_start;
        logic [63:0] d;
        wr(8'h18, 64'd0);
        chk("R2 arm bad illegal", 64'(illegal_pulse), 64'd1);
        chk("R2 arm bad state", 64'(tod_state), 64'd0);
        chk("R12 no rd_valid on write", 64'(rd_valid), 64'd0);
        @(negedge clk);
        chk("R11 pulse one cycle", 64'(illegal_pulse), 64'd0);
        wr(8'h22, 64'd0);
        chk("R4 start in error rejected", 64'(illegal_pulse), 64'd1);
        wr(8'h18, bm(0));
        chk("R2 arm good", 64'(tod_state), 64'd7);
        chk("R2 arm good no illegal", 64'(illegal_pulse), 64'd0);
        wr(8'h21, bm(63));
        chk("R3 load stop", 64'(tod_state), 64'd1);
        rd(8'h24, d);
        chk("R8 runflag stopped", d, 64'd0);
        wr(8'h22, 64'd0);
        chk("R4 start", 64'(tod_state), 64'd2);
        rd(8'h24, d);
        chk("R8 runflag running", d, bm(4));
        rd(8'h08, d);
        chk("R7 status running", d, status_exp(1, 1, 0));
        wr(8'h21, 64'd0);
        chk("R3 load in running illegal", 64'(illegal_pulse), 64'd1);
        chk("R3 load in running state", 64'(tod_state), 64'd2);
        wr(8'h22, 64'd0);
        chk("R4 start in running illegal", 64'(illegal_pulse), 64'd1);
        chk("R4 start in running state", 64'(tod_state), 64'd2);
    endtask

    task automatic t_broadcast;
        wr(8'h16, 64'd0);
        chk("R6 tx inval valid", 64'(tx_valid), 64'd1);
        chk("R6 tx inval kind", 64'(tx_kind), 64'd1);
        chk("R6 no self delivery", 64'(tod_state), 64'd2);
        wr(8'h15, 64'd0);
        chk("R6 tx send kind", {63'd0, tx_valid, tx_kind}, 64'd2);
        rx(1'b0);
        chk("R5 rx send in running illegal", 64'(illegal_pulse), 64'd1);
        chk("R5 rx send in running state", 64'(tod_state), 64'd2);
        rx(1'b1);
        chk("R5 rx inval", 64'(tod_state), 64'd7);
        rx(1'b0);
        chk("R5 rx send from not_set", 64'(tod_state), 64'd2);
        rx(1'b1);
        wr(8'h21, 64'd0);
        chk("R3 load run", 64'(tod_state), 64'd2);
    endtask

    task automatic t_errors;
        logic [63:0] d;
        @(negedge clk);
        hw_err = 8'h05;
        @(negedge clk);
        hw_err = 8'h00;
        chk("R9 hw err state", 64'(tod_state), 64'd0);
        rd(8'h30, d);
        chk("R9 err bits", d, 64'h5);
        wr(8'h30, 64'h4);
        rd(8'h30, d);
        chk("R9 w1c partial", d, 64'h1);
        wr(8'h30, 64'hFF);
        rd(8'h30, d);
        chk("R9 w1c all", d, 64'h0);
    endtask

    task automatic t_ctrl_and_unknown;
        logic [63:0] d;
        wr(8'h07, 64'd0);
        rd(8'h07, d);
        chk("R10 ctrl zero write", d, bm(1) | bm(2));
        wr(8'h07, {32'h1234_5678, 32'hFFFF_FFFF});
        rd(8'h07, d);
        chk("R10 ctrl mask", d, {32'h7234_5678, 32'h0});
        rd(8'h40, d);
        chk("R11 unknown read zero", d, 64'd0);
        chk("R11 unknown read illegal", 64'(illegal_pulse), 64'd1);
        wr(8'h08, 64'd0);
        chk("R11 write read-only illegal", 64'(illegal_pulse), 64'd1);
        rd(8'h21, d);
        chk("R11 read of command offset", {63'd0, illegal_pulse} | d, 64'd1);
    endtask

    task automatic t_roles;
        logic [63:0] d;
        do_reset(0, 1);
        rd(8'h08, d);
        chk("R7 status secondary", d, status_exp(0, 0, 1));
        wr(8'h07, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(8'h07, d);
        chk("R10 ctrl non-primary", d, 64'hBFFF_FFFF_0000_0000);
        do_reset(0, 0);
        rd(8'h07, d);
        chk("R1 ctrl reset non-primary", d, bm(2));
        rd(8'h08, d);
        chk("R7 status neither", d, status_exp(0, 0, 0));
        do_reset(1, 1);
        rd(8'h08, d);
        chk("R7 status both straps", d, status_exp(0, 1, 0));
    endtask

    initial begin
        t_reset();
        t_arm_load_start();
        t_broadcast();
        t_errors();
        t_ctrl_and_unknown();
        t_roles();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule